// File: doc/BRIEF.md
# Fixed-Priority Restart Interrupt Controller

This block decides which of five interrupt sources a processor core takes at an instruction boundary. The sources are a non-maskable trap, a set of maskable restart lines (three by default, called 7.5, 6.5 and 5.5 from highest to lowest priority) and one general request. When a source wins, the block produces either an internal restart vector or, for the general request, a flag telling the core to run an external acknowledge cycle and to keep the program counter from incrementing.

The core raises `sample_i` in the next-to-last clock of each instruction. Requests are looked at only in that clock. The block keeps a global enable flag and one mask bit per restart line. Software sets and clears them through single-cycle command inputs. Every acceptance clears the global enable. Priority is fixed and does not nest: once a handler sets the enable again, any enabled source can be taken, including one of lower priority than the handler's own.

Top module: `irq_rst_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `take_o`=0, `ext_ack_o`=0, `vec_o`=0, `ien_o`=0 and `mask_o`=3'b111 (all restart lines masked).
- R2: A recognised trap is accepted whatever `ien_o` and `mask_o` hold. The result is `vec_o`=8'h24 and `ext_ack_o`=0.
- R3: A trap is recognised only when `trap_i` has had a rising edge since the last trap acceptance and is still high in the strobe clock. A level held high after acceptance is not taken again. A pulse that has fallen before the strobe is not taken.
- R4: Restart line j (`rst_req_i` bit 0 = 5.5, bit 1 = 6.5, bit 2 = 7.5) is accepted only when `ien_o`=1 and `mask_o[j]`=0. Its vectors are 8'h2C, 8'h34 and 8'h3C for bits 0, 1 and 2.
- R5: When several qualified sources are present at one strobe, the winner is, highest first: trap, bit 2, bit 1, bit 0, then the general request.
- R6: An accepted general request gives `ext_ack_o`=1 and `vec_o`=0. It is accepted only when `ien_o`=1 and no higher source qualifies.
- R7: Requests present when `sample_i`=0 produce no acceptance.
- R8: `cmd_ei_i` sets the enable and `cmd_di_i` clears it. If both are raised together, clear wins. Any acceptance clears the enable, even when `cmd_ei_i` is raised in the same strobe clock.
- R9: A mask write (`mask_wr_i`=1) loads `mask_wdata_i` into `mask_o` in the next cycle, and `mask_o` changes at no other time. A strobe in the same clock as a write still uses the old masks.
- R10: Priority does not nest. After a bit-2 restart is accepted and the enable is set again, a lone bit-0 request is accepted.
- R11: Outputs are registered. `take_o` is high in exactly the cycle after an accepting strobe. Outside that cycle `vec_o`=0 and `ext_ack_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Next-to-last-clock strobe; requests are judged only here |
| trap_i | input | 1 | Non-maskable trap request |
| rst_req_i | input | 3 | Restart requests, bit 2 highest priority |
| gen_req_i | input | 1 | General request served by an external acknowledge |
| cmd_ei_i | input | 1 | Set the global enable |
| cmd_di_i | input | 1 | Clear the global enable |
| mask_wr_i | input | 1 | Write strobe for the mask bits |
| mask_wdata_i | input | 3 | New mask values, 1 = masked |
| take_o | output | 1 | One-cycle accept pulse |
| vec_o | output | 8 | Restart address of the accepted source; 0 for the general request |
| ext_ack_o | output | 1 | The accepted source needs an external acknowledge; the core holds its program counter |
| ien_o | output | 1 | Global enable state |
| mask_o | output | 3 | Mask state |

## Verification
Each result is due exactly one clock after the edge that causes it. Accept, vector and acknowledge appear in the cycle after the strobe edge. Enable and mask state appear in the cycle after the command edge. A trap counts as armed only one edge after its rising edge. The bench drives every input on a falling edge and reads every output on the following falling edge, so each value is read half a period after the single register it passes through has loaded. The sweep walks all 512 combinations of trap, general request, the three restart lines, the three masks and the enable, and derives each expected vector from the priority order and the vector arithmetic.

// File: rtl/irq_rst_pkg.sv
package irq_rst_pkg;

   // Which kind of source won arbitration in the current strobe clock
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_TRAP = 2'd1,
      SRC_RST  = 2'd2,
      SRC_GEN  = 2'd3
   } src_kind_e;

   // Index width for a set of n restart lines
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_trap_sense.sv
module irq_trap_sense #(
   parameter bit LEVEL_QUAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic trap_i,
   input  logic clr_i,
   output logic armed_o
);
   logic prev_q;
   logic seen_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         prev_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         prev_q <= trap_i;
         // a fresh rising edge re-arms even in the clock of an acceptance
         if (trap_i && !prev_q)
            seen_q <= 1'b1;
         else if (clr_i)
            seen_q <= 1'b0;
      end
   end

   generate
      if (LEVEL_QUAL) begin : g_edge_and_level
         assign armed_o = seen_q & trap_i;
      end else begin : g_edge_only
         assign armed_o = seen_q;
      end
   endgenerate

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs #(
   parameter int NUM_RST       = 3,
   parameter bit MASK_AT_RESET = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic               ei_i,
   input  logic               di_i,
   input  logic               acc_i,
   input  logic               mask_wr_i,
   input  logic [NUM_RST-1:0] mask_wdata_i,
   output logic               ien_o,
   output logic [NUM_RST-1:0] mask_o
);
   logic ien_q;

   // acceptance beats disable beats enable
   always_ff @(posedge clk_i) begin
      if (!rst_n_i)
         ien_q <= 1'b0;
      else if (acc_i)
         ien_q <= 1'b0;
      else if (di_i)
         ien_q <= 1'b0;
      else if (ei_i)
         ien_q <= 1'b1;
   end

   assign ien_o = ien_q;

   genvar j;
   generate
      for (j = 0; j < NUM_RST; j++) begin : g_mask
         logic bit_q;
         always_ff @(posedge clk_i) begin
            if (!rst_n_i)
               bit_q <= MASK_AT_RESET;
            else if (mask_wr_i)
               bit_q <= mask_wdata_i[j];
         end
         assign mask_o[j] = bit_q;
      end
   endgenerate

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_rst_pkg::*;
#(
   parameter int NUM_RST = 3,
   parameter int IDX_W   = 2
) (
   input  logic               trap_ok_i,
   input  logic [NUM_RST-1:0] rst_ok_i,
   input  logic               gen_ok_i,
   output src_kind_e          kind_o,
   output logic [IDX_W-1:0]   idx_o
);
   logic hit;

   always_comb begin
      hit   = 1'b0;
      idx_o = '0;
      // ascending scan: the highest qualified index is written last
      for (int j = 0; j < NUM_RST; j++) begin
         if (rst_ok_i[j]) begin
            hit   = 1'b1;
            idx_o = IDX_W'(j);
         end
      end
      if (trap_ok_i)
         kind_o = SRC_TRAP;
      else if (hit)
         kind_o = SRC_RST;
      else if (gen_ok_i)
         kind_o = SRC_GEN;
      else
         kind_o = SRC_NONE;
   end

endmodule

// File: rtl/irq_rst_ctrl.sv
module irq_rst_ctrl
   import irq_rst_pkg::*;
#(
   parameter int NUM_RST         = 3,
   parameter int VEC_W           = 8,
   parameter int TRAP_VEC        = 'h24,
   parameter int VEC_STEP        = 8,
   parameter bit MASK_AT_RESET   = 1'b1,
   parameter bit TRAP_LEVEL_QUAL = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic               sample_i,
   input  logic               trap_i,
   input  logic [NUM_RST-1:0] rst_req_i,
   input  logic               gen_req_i,
   input  logic               cmd_ei_i,
   input  logic               cmd_di_i,
   input  logic               mask_wr_i,
   input  logic [NUM_RST-1:0] mask_wdata_i,
   output logic               take_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic               ext_ack_o,
   output logic               ien_o,
   output logic [NUM_RST-1:0] mask_o
);
   localparam int IDX_W   = idx_width(NUM_RST);
   localparam int TOP_VEC = TRAP_VEC + VEC_STEP * NUM_RST;

   generate
      if (NUM_RST < 1 || NUM_RST > 8) begin : g_bad_count
         $error("irq_rst_ctrl: NUM_RST must lie in 1..8");
      end
      if (TOP_VEC >= (1 << VEC_W)) begin : g_bad_width
         $error("irq_rst_ctrl: restart vectors do not fit in VEC_W bits");
      end
      if (VEC_STEP < 1) begin : g_bad_step
         $error("irq_rst_ctrl: VEC_STEP must be positive");
      end
   endgenerate

   logic               trap_ok;
   logic               trap_clr;
   logic [NUM_RST-1:0] rst_ok;
   logic               gen_ok;
   logic               accept;
   src_kind_e          kind;
   logic [IDX_W-1:0]   idx;
   logic [VEC_W-1:0]   vec_n;
   logic [VEC_W-1:0]   rst_vec_tab [NUM_RST];

   logic               take_q;
   logic [VEC_W-1:0]   vec_q;
   logic               ext_q;

   irq_trap_sense #(
      .LEVEL_QUAL (TRAP_LEVEL_QUAL)
   ) u_trap (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .trap_i  (trap_i),
      .clr_i   (trap_clr),
      .armed_o (trap_ok)
   );

   irq_state_regs #(
      .NUM_RST       (NUM_RST),
      .MASK_AT_RESET (MASK_AT_RESET)
   ) u_state (
      .clk_i        (clk_i),
      .rst_n_i      (rst_n_i),
      .ei_i         (cmd_ei_i),
      .di_i         (cmd_di_i),
      .acc_i        (accept),
      .mask_wr_i    (mask_wr_i),
      .mask_wdata_i (mask_wdata_i),
      .ien_o        (ien_o),
      .mask_o       (mask_o)
   );

   // qualification by enable and mask; trap bypasses both
   assign rst_ok = rst_req_i & ~mask_o & {NUM_RST{ien_o}};
   assign gen_ok = gen_req_i & ien_o;

   irq_prio_pick #(
      .NUM_RST (NUM_RST),
      .IDX_W   (IDX_W)
   ) u_pick (
      .trap_ok_i (trap_ok),
      .rst_ok_i  (rst_ok),
      .gen_ok_i  (gen_ok),
      .kind_o    (kind),
      .idx_o     (idx)
   );

   // restart line j sits one step above line j-1, the trap one step below line 0
   genvar j;
   generate
      for (j = 0; j < NUM_RST; j++) begin : g_vec
         assign rst_vec_tab[j] = VEC_W'(TRAP_VEC + VEC_STEP * (j + 1));
      end
   endgenerate

   always_comb begin
      unique case (kind)
         SRC_TRAP: vec_n = VEC_W'(TRAP_VEC);
         SRC_RST:  vec_n = rst_vec_tab[idx];
         default:  vec_n = '0;
      endcase
   end

   assign accept   = sample_i && (kind != SRC_NONE);
   assign trap_clr = sample_i && (kind == SRC_TRAP);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         take_q <= 1'b0;
         vec_q  <= '0;
         ext_q  <= 1'b0;
      end else begin
         take_q <= accept;
         vec_q  <= accept ? vec_n : '0;
         ext_q  <= accept && (kind == SRC_GEN);
      end
   end

   assign take_o    = take_q;
   assign vec_o     = vec_q;
   assign ext_ack_o = ext_q;

endmodule

// File: rtl/irq_rst_ctrl_chk.sv
module irq_rst_ctrl_chk #(
   parameter int NUM_RST  = 3,
   parameter int VEC_W    = 8,
   parameter int TRAP_VEC = 'h24
) (
   input logic               clk_i,
   input logic               rst_n_i,
   input logic               sample_i,
   input logic               trap_i,
   input logic               cmd_ei_i,
   input logic               cmd_di_i,
   input logic               mask_wr_i,
   input logic               take_o,
   input logic [VEC_W-1:0]   vec_o,
   input logic               ext_ack_o,
   input logic               ien_o,
   input logic [NUM_RST-1:0] mask_o
);
   AST_TAKE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      take_o |-> $past(sample_i)); // R7

   AST_ACCEPT_CLEARS_IEN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      take_o |-> !ien_o); // R8

   AST_EI_SETS_IEN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (cmd_ei_i && !cmd_di_i) |=> (ien_o || take_o)); // R8

   AST_DI_CLEARS_IEN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cmd_di_i |=> !ien_o); // R8

   AST_GEN_NEEDS_IEN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ext_ack_o |-> ($past(ien_o) && take_o && vec_o == '0)); // R6

   AST_RST_NEEDS_IEN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (take_o && !ext_ack_o && vec_o != VEC_W'(TRAP_VEC)) |-> $past(ien_o)); // R4

   AST_TRAP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (take_o && vec_o == VEC_W'(TRAP_VEC)) |-> $past(trap_i)); // R3

   AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !take_o |-> (vec_o == '0 && !ext_ack_o)); // R11

   AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !$past(mask_wr_i) |-> $stable(mask_o)); // R9

endmodule

bind irq_rst_ctrl irq_rst_ctrl_chk #(
   .NUM_RST  (NUM_RST),
   .VEC_W    (VEC_W),
   .TRAP_VEC (TRAP_VEC)
) u_chk (
   .clk_i     (clk_i),
   .rst_n_i   (rst_n_i),
   .sample_i  (sample_i),
   .trap_i    (trap_i),
   .cmd_ei_i  (cmd_ei_i),
   .cmd_di_i  (cmd_di_i),
   .mask_wr_i (mask_wr_i),
   .take_o    (take_o),
   .vec_o     (vec_o),
   .ext_ack_o (ext_ack_o),
   .ien_o     (ien_o),
   .mask_o    (mask_o)
);

// File: tb/sim_irq_rst_ctrl.sv
module sim_irq_rst_ctrl;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n_i;
   logic       sample_i, trap_i, gen_req_i, cmd_ei_i, cmd_di_i, mask_wr_i;
   logic [2:0] rst_req_i, mask_wdata_i, mask_o;
   logic       take_o, ext_ack_o, ien_o;
   logic [7:0] vec_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   irq_rst_ctrl u0 (
      .clk_i(clk), .rst_n_i(rst_n_i), .sample_i(sample_i), .trap_i(trap_i),
      .rst_req_i(rst_req_i), .gen_req_i(gen_req_i), .cmd_ei_i(cmd_ei_i),
      .cmd_di_i(cmd_di_i), .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
      .take_o(take_o), .vec_o(vec_o), .ext_ack_o(ext_ack_o), .ien_o(ien_o),
      .mask_o(mask_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      sample_i = 0; cmd_ei_i = 0; cmd_di_i = 0; mask_wr_i = 0;
   endtask

   // drive a strobe now, read the result one edge later
   task automatic strobe_and_read(output logic tk, output logic [7:0] vc, output logic ex);
      sample_i = 1;
      @(negedge clk);
      idle_inputs();
      tk = take_o; vc = vec_o; ex = ext_ack_o;
   endtask

   task automatic set_state(input logic en, input logic [2:0] m);
      mask_wr_i = 1; mask_wdata_i = m; cmd_ei_i = en; cmd_di_i = !en;
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic       tk, ex;
      logic [7:0] vc;
      rst_n_i = 0; trap_i = 0; rst_req_i = 0; gen_req_i = 0; mask_wdata_i = 0;
      idle_inputs();
      repeat (3) @(negedge clk);
      // R1: state while reset is held
      chk("R1", "take", take_o, 0);
      chk("R1", "ien", ien_o, 0);
      chk("R1", "mask", mask_o, 3'b111);
      rst_n_i = 1;
      @(negedge clk);
      chk("R1", "take", take_o, 0);
      chk("R1", "ext", ext_ack_o, 0);
      chk("R1", "vec", vec_o, 0);
      chk("R1", "ien", ien_o, 0);
      chk("R1", "mask", mask_o, 3'b111);

      // sweep: R2 R4 R5 R6 R8 R9 R11
      for (int c = 0; c < 512; c++) begin
         logic       t, g, e;
         logic [2:0] r, m;
         int         ev;
         logic       et, ee;
         t = c[0]; g = c[1]; r = c[4:2]; m = c[7:5]; e = c[8];
         trap_i = 0; rst_req_i = r; gen_req_i = g;
         set_state(e, m);
         trap_i = t;
         chk("R9", "mask after write", mask_o, m);
         chk("R8", "ien after command", ien_o, e);
         @(negedge clk);
         et = 1; ee = 0; ev = 0;
         if (t) ev = 'h24;
         else if (e && r[2] && !m[2]) ev = 'h3C;
         else if (e && r[1] && !m[1]) ev = 'h34;
         else if (e && r[0] && !m[0]) ev = 'h2C;
         else if (e && g) ee = 1;
         else et = 0;
         strobe_and_read(tk, vc, ex);
         chk("R5", "take", tk, et);
         chk("R5", "vec", vc, ev);
         chk("R6", "ext", ex, ee);
         @(negedge clk);
         chk("R8", "ien after strobe", ien_o, et ? 0 : e);
         chk("R11", "take one cycle", take_o, 0);
      end

      // R3: trap held high after acceptance is not taken again
      trap_i = 0; rst_req_i = 0; gen_req_i = 0;
      set_state(0, 3'b111);
      trap_i = 1;
      @(negedge clk);
      strobe_and_read(tk, vc, ex);
      chk("R2", "trap with ien=0 and masks", vc, 'h24);
      @(negedge clk);
      strobe_and_read(tk, vc, ex);
      chk("R3", "held trap not retaken", tk, 0);
      // R3: pulse gone before strobe
      trap_i = 0; @(negedge clk);
      trap_i = 1; @(negedge clk);
      trap_i = 0; @(negedge clk);
      strobe_and_read(tk, vc, ex);
      chk("R3", "fallen pulse not taken", tk, 0);
      trap_i = 1; @(negedge clk);
      strobe_and_read(tk, vc, ex);
      chk("R3", "new edge taken", vc, 'h24);
      trap_i = 0;

      // R7: no strobe, no acceptance
      set_state(1, 3'b000);
      rst_req_i = 3'b111; gen_req_i = 1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R7", "take without strobe", take_o, 0);
      end
      chk("R7", "ien untouched", ien_o, 1);

      // R8: acceptance beats enable command in the same clock
      cmd_ei_i = 1;
      strobe_and_read(tk, vc, ex);
      chk("R8", "accept with ei", vc, 'h3C);
      chk("R8", "ien cleared despite ei", ien_o, 0);

      // R8: disable wins over enable
      cmd_ei_i = 1; cmd_di_i = 1;
      @(negedge clk); idle_inputs();
      chk("R8", "di beats ei", ien_o, 0);

      // R9: strobe in the write clock uses old masks
      rst_req_i = 3'b100; gen_req_i = 0;
      set_state(1, 3'b111);
      mask_wr_i = 1; mask_wdata_i = 3'b000;
      strobe_and_read(tk, vc, ex);
      chk("R9", "old mask at write strobe", tk, 0);
      chk("R9", "new mask visible", mask_o, 3'b000);
      strobe_and_read(tk, vc, ex);
      chk("R9", "new mask at next strobe", vc, 'h3C);

      // R10: lower priority taken after re-enable inside a handler
      cmd_ei_i = 1; @(negedge clk); idle_inputs();
      rst_req_i = 3'b001;
      strobe_and_read(tk, vc, ex);
      chk("R10", "5.5 inside 7.5 handler", vc, 'h2C);
      chk("R10", "take", tk, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule